// File: doc/BRIEF.md
# Shared Ready/Data Serial Output Port

This block drives one output pin that does two jobs for a converter. While no result is being offered the pin sits high. When a new 24-bit result is handed in, the pin runs a fixed announcement: a transfer phase at high level, a short low pulse, and a high phase. It then becomes a serial data line for a fixed window. The host reads the result by sending serial clock pulses, and each falling edge of that clock moves the pin to the next bit, most significant bit first. An end-of-window phase closes the read and the pin returns to its ready level.

Partial reads, over-reads and reads that never happen all leave a defined level on the pin. A result offered while a window is still open is held back. It is announced only after that window closes, and if several arrive, the latest one wins. The host serial clock is brought into the system clock domain by a synchroniser inside the block. Every phase length is a parameter counted in system clocks.

Top module: `rdy_data_port`

## Requirements
- R1: After reset the pin is high and the block waits in ready mode.
- R2: After a result strobe the pin stays high for the transfer phase (XFER_CYC clocks), is low for exactly LOW_CYC clocks, and then is high for exactly HIGH_CYC clocks. The low pulse begins XFER_CYC+2 clocks after the clock in which the strobe is sampled.
- R3: Data mode lasts DATA_CYC clocks. With no serial clock, the pin shows bit 23 (the most significant bit) of the result for the whole window.
- R4: In data mode, after k falling edges of the serial clock (1 ≤ k ≤ 23), the pin shows bit 23−k of the result.
- R5: After a partial read of k < 24 falling edges, bit 23−k stays on the pin until the end-of-window phase begins.
- R6: After the 24th falling edge the pin keeps bit 0. From the 25th falling edge on, the pin is low until the end-of-window phase begins.
- R7: The bit pointer is cleared on entry to the transfer phase and on entry to the end-of-window phase, so every window starts at bit 23, whatever the previous read left behind.
- R8: The pin is high during the end-of-window phase (EOW_CYC clocks) and stays high afterwards until the next strobe.
- R9: A strobe that arrives while a window is in progress does not change the current window. The latest such word is announced after the end-of-window phase, after one ready-mode clock.
- R10: Falling edges of the serial clock outside data mode do not move the bit pointer.
- R11: A result whose bit 23 is 1 keeps the pin high without a break from the end of the low pulse to the end of the window when no serial clock arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_stb | input | 1 | New-result strobe, one system clock wide |
| res_word | input | 24 | Result word, sampled with the strobe |
| host_sclk | input | 1 | Host serial clock, asynchronous, idle low |
| line_out | output | 1 | Shared ready/data pin |

## Verification
The assertions assume that the host serial clock holds each level for at least as many system clocks as the synchroniser has stages, so that every falling edge shows up as one detected edge, and that it rests low between reads. They also assume every phase length parameter is at least one. The stimulus holds each serial clock level for four system clocks and changes inputs only on falling system clock edges. It sends strobes only as one-clock pulses, both in ready mode and inside a data window.

// File: rtl/rdp_pkg.sv
// Shared types for the ready/data serial output port.
package rdp_pkg;
    // Phases of the shared pin, in the order the sequencer visits them.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_XFER = 3'd1,
        PH_LOW  = 3'd2,
        PH_HIGH = 3'd3,
        PH_DATA = 3'd4,
        PH_EOW  = 3'd5
    } phase_t;
endpackage

// File: rtl/rdp_sclk_edge.sv
// Brings the asynchronous host serial clock into the system domain and flags
// each falling edge for one system clock.
// Assumes each serial clock level lasts longer than STAGES system clocks.
module rdp_sclk_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchroniser chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], sclk_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A falling edge is seen when the synchronised level drops.
    assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/rdp_result_hold.sv
// Holds the newest result word until the sequencer takes it, and keeps the
// word being shifted out stable for the whole window.
// Assumes load is only raised when the port is in ready mode.
module rdp_result_hold #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] word_in,
    input  logic         load,
    output logic         pend,
    output logic [W-1:0] word_q
);
    logic [W-1:0] pend_word;

    // Capture strobed words; a newer strobe replaces an older pending one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_word <= '0;
        end else begin
            if (stb) begin
                pend      <= 1'b1;
                pend_word <= word_in;
            end else if (load) begin
                pend <= 1'b0;
            end
        end
    end

    // Move the pending word into the active register when a window starts.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else if (load) word_q <= pend_word;
    end

    // R9: the active word changes only when a new window is started.
    assert_word_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_q));
endmodule

// File: rtl/rdp_sequencer.sv
// Steps the shared pin through its phases and times each phase with one
// down-counter. It requests a word load when ready mode sees a pending result,
// and a pointer clear on entry to the transfer and end-of-window phases.
// Assumes every phase length parameter is at least one.
module rdp_sequencer
    import rdp_pkg::*;
#(
    parameter int XFER_CYC = 6,
    parameter int LOW_CYC  = 4,
    parameter int HIGH_CYC = 8,
    parameter int DATA_CYC = 400,
    parameter int EOW_CYC  = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pend,
    output phase_t phase,
    output logic   load,
    output logic   ptr_clr
);
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAXD = max2(max2(max2(XFER_CYC, LOW_CYC), max2(HIGH_CYC, DATA_CYC)), EOW_CYC);
    localparam int CW   = $clog2(MAXD + 1);

    logic [CW-1:0] cnt_q;
    phase_t        nxt;

    // Length minus one of the phase being entered.
    function automatic logic [CW-1:0] dur_of(input phase_t p);
        case (p)
            PH_XFER: return CW'(XFER_CYC - 1);
            PH_LOW:  return CW'(LOW_CYC - 1);
            PH_HIGH: return CW'(HIGH_CYC - 1);
            PH_DATA: return CW'(DATA_CYC - 1);
            PH_EOW:  return CW'(EOW_CYC - 1);
            default: return '0;
        endcase
    endfunction

    // Next-phase choice; a timed phase moves on once its counter reaches zero.
    always_comb begin
        nxt  = phase;
        load = 1'b0;
        case (phase)
            PH_IDLE: if (pend) begin
                nxt  = PH_XFER;
                load = 1'b1;
            end
            PH_XFER: if (cnt_q == '0) nxt = PH_LOW;
            PH_LOW:  if (cnt_q == '0) nxt = PH_HIGH;
            PH_HIGH: if (cnt_q == '0) nxt = PH_DATA;
            PH_DATA: if (cnt_q == '0) nxt = PH_EOW;
            PH_EOW:  if (cnt_q == '0) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    // Pointer clear on entry to the transfer or end-of-window phase.
    assign ptr_clr = (nxt != phase) && (nxt == PH_XFER || nxt == PH_EOW);

    // Phase register and its duration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            phase <= nxt;
            if (nxt != phase)      cnt_q <= dur_of(nxt);
            else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
        end
    end

    // R2: the low pulse is always preceded by the transfer phase.
    assert_low_after_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW && $past(phase) != PH_LOW) |-> $past(phase) == PH_XFER);
    // R2: data mode is always entered from the high phase.
    assert_data_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && $past(phase) != PH_DATA) |-> $past(phase) == PH_HIGH);
    // R8: ready mode holds while nothing is pending.
    assert_idle_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !pend) |=> phase == PH_IDLE);
    // R9: a window in progress runs to its end-of-window phase before the next starts.
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_XFER && $past(phase) != PH_XFER) |-> $past(phase) == PH_IDLE);
endmodule

// File: rtl/rdp_bit_shifter.sv
// Keeps the bit pointer for data mode and selects the level for the pin.
// The pointer counts falling serial clock edges and saturates one past the
// last bit, which marks an over-read.
// Assumes ptr_clr comes from the sequencer on phase entry.
module rdp_bit_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word,
    input  logic         in_data,
    input  logic         fall,
    input  logic         ptr_clr,
    output logic         bit_out
);
    localparam int PW = $clog2(W + 2);
    localparam logic [PW-1:0] PTR_OVER = PW'(W + 1);

    logic [PW-1:0] ptr_q;

    // Pointer: cleared on phase entry, advanced by falling edges in data mode only.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ptr_q <= '0;
        else if (ptr_clr)                            ptr_q <= '0;
        else if (in_data && fall && ptr_q != PTR_OVER) ptr_q <= ptr_q + PW'(1);
    end

    // Level select: bit W-1-ptr, then the last bit held, then low on over-read.
    always_comb begin
        bit_out = 1'b0;
        if (ptr_q < PW'(W))       bit_out = word[W - 1 - int'(ptr_q)];
        else if (ptr_q == PW'(W)) bit_out = word[0];
    end

    // R7: a clear request empties the pointer on the next clock.
    assert_ptr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> ptr_q == '0);
    // R4: each detected falling edge in data mode moves exactly one bit.
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && fall && !ptr_clr && ptr_q != PTR_OVER) |=> ptr_q == $past(ptr_q) + PW'(1));
    // R10: outside data mode the pointer does not move except when cleared.
    assert_ptr_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_data && !ptr_clr) |=> $stable(ptr_q));
    // R6: once past the last bit the pointer stays there until cleared.
    assert_ptr_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == PTR_OVER && !ptr_clr) |=> ptr_q == PTR_OVER);
endmodule

// File: rtl/rdy_data_port.sv
// Shared ready/data serial output port. Announces each new result with a
// timed high-low-high pattern, then shifts the result out MSB first on
// falling edges of the host serial clock, then closes the window.
// Assumes res_stb is a single-clock pulse and host_sclk idles low.
module rdy_data_port
    import rdp_pkg::*;
#(
    parameter int W           = 24,
    parameter int SYNC_STAGES = 2,
    parameter int XFER_CYC    = 6,
    parameter int LOW_CYC     = 4,
    parameter int HIGH_CYC    = 8,
    parameter int DATA_CYC    = 400,
    parameter int EOW_CYC     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_stb,
    input  logic [W-1:0] res_word,
    input  logic         host_sclk,
    output logic         line_out
);
    phase_t       phase;
    logic         fall, pend, load, ptr_clr, bit_out;
    logic [W-1:0] word_q;

    rdp_sclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .sclk_in(host_sclk), .fall(fall)
    );

    rdp_result_hold #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .stb(res_stb), .word_in(res_word),
        .load(load), .pend(pend), .word_q(word_q)
    );

    rdp_sequencer #(
        .XFER_CYC(XFER_CYC), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC),
        .DATA_CYC(DATA_CYC), .EOW_CYC(EOW_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .pend(pend),
        .phase(phase), .load(load), .ptr_clr(ptr_clr)
    );

    rdp_bit_shifter #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .word(word_q), .in_data(phase == PH_DATA),
        .fall(fall), .ptr_clr(ptr_clr), .bit_out(bit_out)
    );

    // Pin level: low pulse, serial data, or the high ready level.
    always_comb begin
        case (phase)
            PH_LOW:  line_out = 1'b0;
            PH_DATA: line_out = bit_out;
            default: line_out = 1'b1;
        endcase
    end

    // R8: the pin is only low during the low pulse or in data mode.
    assert_low_only_pulse_or_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_out |-> (phase == PH_LOW || phase == PH_DATA));
    // R1: reset leaves the pin at the ready level.
    assert_reset_high_R1: assert property (@(posedge clk)
        !rst_n |=> line_out);
endmodule

// File: tb/test_rdy_data_port.sv
// Directed bench for the shared ready/data serial output port.
module test_rdy_data_port;
    localparam int CLK_PERIOD = 10;
    localparam int X = 6, L = 4, H = 8, D = 400, E = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_stb = 1'b0;
    logic [23:0] res_word = '0;
    logic        host_sclk = 1'b0;
    logic        line_out;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    rdy_data_port #(
        .W(24), .SYNC_STAGES(2), .XFER_CYC(X), .LOW_CYC(L),
        .HIGH_CYC(H), .DATA_CYC(D), .EOW_CYC(E)
    ) i_rdy_data_port (
        .clk(clk), .rst_n(rst_n), .res_stb(res_stb), .res_word(res_word),
        .host_sclk(host_sclk), .line_out(line_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Strobe a word; returns the strobe cycle and the first data-mode cycle.
    task automatic start_result(input logic [23:0] w, output int s, output int ds);
        @(negedge clk);
        s = cyc;
        res_stb = 1'b1;
        res_word = w;
        @(negedge clk);
        res_stb = 1'b0;
        ds = s + 2 + X + L + H;
    endtask

    task automatic pulse_sclk();
        host_sclk = 1'b1;
        repeat (4) @(negedge clk);
        host_sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "pin after reset", line_out, 1'b1);
    endtask

    task automatic t_phases();
        int s, ds;
        start_result(24'h3CA55A, s, ds);
        wait_until(s + 1 + X); chk("R2", "end of transfer phase", line_out, 1'b1);
        wait_until(s + 2 + X); chk("R2", "first low cycle", line_out, 1'b0);
        wait_until(s + 1 + X + L); chk("R2", "last low cycle", line_out, 1'b0);
        wait_until(s + 2 + X + L); chk("R2", "first high cycle", line_out, 1'b1);
        wait_until(ds - 1); chk("R2", "last high cycle", line_out, 1'b1);
        wait_until(ds); chk("R3", "MSB at data start", line_out, 1'b0);
        wait_until(ds + D - 1); chk("R3", "MSB at window end", line_out, 1'b0);
        wait_until(ds + D); chk("R8", "end-of-window level", line_out, 1'b1);
        wait_until(ds + D + E + 20); chk("R8", "ready level after window", line_out, 1'b1);
    endtask

    task automatic t_full_read();
        int s, ds;
        logic [23:0] w = 24'hB4E21D;
        start_result(w, s, ds);
        wait_until(ds);
        chk("R4", "bit 23 before clocks", line_out, w[23]);
        for (int k = 1; k <= 23; k++) begin
            pulse_sclk();
            chk("R4", $sformatf("bit %0d after %0d edges", 23 - k, k), line_out, w[23 - k]);
        end
        pulse_sclk(); chk("R6", "24th edge holds bit 0", line_out, w[0]);
        pulse_sclk(); chk("R6", "25th edge drives low", line_out, 1'b0);
        pulse_sclk(); chk("R6", "26th edge stays low", line_out, 1'b0);
        wait_until(ds + D - 1); chk("R6", "over-read low until window end", line_out, 1'b0);
        wait_until(ds + D); chk("R8", "high after over-read window", line_out, 1'b1);
        wait_until(ds + D + E + 2);
    endtask

    task automatic t_reread();
        int s, ds;
        logic [23:0] w = 24'h4F1234;
        start_result(w, s, ds);
        wait_until(ds); chk("R7", "new window starts at bit 23", line_out, w[23]);
        pulse_sclk(); chk("R7", "first edge gives bit 22", line_out, w[22]);
        wait_until(ds + D + E + 2);
    endtask

    task automatic t_partial();
        int s, ds;
        logic [23:0] w = 24'h5B3C17;
        start_result(w, s, ds);
        wait_until(ds);
        repeat (7) pulse_sclk();
        chk("R5", "bit 16 after 7 edges", line_out, w[16]);
        wait_until(ds + 200); chk("R5", "bit 16 held mid-window", line_out, w[16]);
        wait_until(ds + D - 1); chk("R5", "bit 16 held to window end", line_out, w[16]);
        wait_until(ds + D); chk("R5", "end-of-window replaces held bit", line_out, 1'b1);
        wait_until(ds + D + E + 2);
    endtask

    task automatic t_negative();
        int s, ds;
        bit all_high = 1'b1;
        start_result(24'h800001, s, ds);
        wait_until(s + 2 + X + L);
        while (cyc < ds + D + E + 5) begin
            if (line_out !== 1'b1) all_high = 1'b0;
            @(negedge clk);
        end
        chk("R11", "pin stays high for negative result", all_high, 1'b1);
    endtask

    task automatic t_ignore();
        int s, ds;
        logic [23:0] w = 24'h9A0F0F;
        repeat (3) pulse_sclk();
        chk("R10", "ready level under idle clocks", line_out, 1'b1);
        start_result(w, s, ds);
        repeat (2) pulse_sclk();
        wait_until(ds); chk("R10", "bit 23 despite early clocks", line_out, w[23]);
        pulse_sclk(); chk("R10", "bit 22 after one data edge", line_out, w[22]);
        wait_until(ds + D + E + 2);
    endtask

    task automatic t_pending();
        int s, ds, ds2, lo;
        logic [23:0] a = 24'hE00000, b = 24'h7FFFFF, c = 24'h355555;
        start_result(a, s, ds);
        wait_until(ds + 10);
        res_stb = 1'b1; res_word = b; @(negedge clk); res_stb = 1'b0;
        wait_until(ds + 30);
        res_stb = 1'b1; res_word = c; @(negedge clk); res_stb = 1'b0;
        wait_until(ds + 40); chk("R9", "current window keeps its MSB", line_out, a[23]);
        lo = ds + D + E + 1 + X;
        wait_until(lo - 1); chk("R9", "high before held announcement", line_out, 1'b1);
        wait_until(lo); chk("R9", "held result low pulse", line_out, 1'b0);
        ds2 = lo + L + H;
        wait_until(ds2 - 1); chk("R9", "high phase of held result", line_out, 1'b1);
        wait_until(ds2); chk("R9", "latest held word bit 23", line_out, c[23]);
        pulse_sclk(); chk("R9", "latest held word bit 22", line_out, c[22]);
        pulse_sclk(); chk("R9", "latest held word bit 21", line_out, c[21]);
        wait_until(ds2 + D + E + 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_phases();
        t_full_read();
        t_reread();
        t_partial();
        t_negative();
        t_ignore();
        t_pending();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule